// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block predicts the direction of conditional branches by combining a per-address table with a short record of recent branch outcomes. Each table entry, selected by low instruction-address bits, holds one small saturating counter per possible pattern of the last two resolved outcomes. The global outcome record picks which of an entry's counters to consult. The counter's upper bit gives the prediction.

A front end presents a fetch address on the predict port and reads back a taken or not-taken answer in the same cycle. When a branch resolves, the back end presents its address and its real outcome on the update port. The selected counter moves one step toward that outcome, and the outcome is shifted into the global record. The table depth is derived from a storage budget. It is the largest power-of-two entry count whose counters fit in the budget. The default budget of 10000 bits gives 1024 entries of eight bits each.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter holds 01 and the outcome history holds 00, so every address predicts not-taken.
- R2: The prediction is the upper bit of the selected counter: values 10 and 11 predict taken, and values 00 and 01 predict not-taken.
- R3: On an update, a taken outcome adds one to the selected counter and a not-taken outcome subtracts one. The counter stays at 11 on further taken outcomes and at 00 on further not-taken outcomes.
- R4: The entry is chosen by address bits [11:2], giving 1024 entries from the 10000-bit budget. Addresses that differ only in bits [1:0] or only above bit 11 share one entry.
- R5: The counter within an entry is chosen by the 2-bit history. Bit 0 is the newest outcome and bit 1 the one before it, with taken written as 1. For example, not-taken followed by taken selects counter 01.
- R6: An update adjusts the counter selected by the history as it stood before that update. The history then becomes {previous bit 0, new outcome}. No other counter changes.
- R7: While the update-valid input is low, neither the counters nor the history change, whatever the other update inputs carry.
- R8: The prediction follows the predict address combinationally from the current state. An update presented in the same cycle becomes visible only after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predPc | input | 32 | Address to predict |
| predTaken | output | 1 | 1 = predicted taken |
| updValid | input | 1 | Resolved branch present this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench drives long runs of mixed outcomes, and a design that wraps a counter instead of saturating would flip a strongly-biased prediction. It sends repeated taken and repeated not-taken outcomes to one address to reach both saturation points. It interleaves another branch between updates to one entry, so that a design indexing counters with the newest and oldest bits swapped, or with the post-update history, would adjust or read the wrong counter. It checks that addresses aliasing through bits [1:0] and above bit 11 share state while a neighbouring word does not. It also checks that a held-low valid leaves a one-step-from-flipping counter untouched, and that a same-cycle update does not leak into the current prediction.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

  // strobes from control to datapath for one resolved branch
  typedef struct packed {
    logic wrEn;   // selected counter changes
    logic inc;    // step up
    logic dec;    // step down
    logic shift;  // history takes in a new outcome
    logic bitIn;  // outcome to shift in
  } bpStrobe_t;

  // largest power of two entry count whose storage fits in the budget
  function automatic int calcEntries(input int budgetBits, input int bitsPerEntry);
    int e;
    e = 1;
    while ((e * 2 * bitsPerEntry) <= budgetBits) e = e * 2;
    return e;
  endfunction

endpackage

// File: rtl/corr_bp_ctrl.sv
module corr_bp_ctrl
  import corr_bp_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [CTR_W-1:0] updCtr,
  output bpStrobe_t        strobe
);

  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  logic atTop;
  logic atBottom;

  assign atTop    = (updCtr == CTR_MAX);
  assign atBottom = (updCtr == CTR_MIN);

  always_comb begin
    strobe       = '0;
    strobe.shift = updValid;
    strobe.bitIn = updTaken;
    strobe.inc   = updValid &&  updTaken && !atTop;
    strobe.dec   = updValid && !updTaken && !atBottom;
    strobe.wrEn  = strobe.inc || strobe.dec;
  end

  // R3: never both directions at once
  p_step_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.inc, strobe.dec}));

  // R3: no step beyond either end of the counter range
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc |-> (updCtr != CTR_MAX));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> (updCtr != CTR_MIN));

endmodule

// File: rtl/corr_bp_datapath.sv
module corr_bp_datapath
  import corr_bp_pkg::*;
#(
  parameter int ENTRIES  = 1024,
  parameter int HIST_LEN = 2,
  parameter int CTR_W    = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int SEL_N   = 1 << HIST_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] predIdx,
  input  logic [IDX_W-1:0] updIdx,
  input  bpStrobe_t        strobe,
  output logic [CTR_W-1:0] updCtr,
  output logic             predTaken
);

  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1);
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;

  logic [CTR_W-1:0]    ctrTab [ENTRIES][SEL_N];
  logic [HIST_LEN-1:0] hist;
  logic [CTR_W-1:0]    predCtr;
  logic [CTR_W-1:0]    nextCtr;

  assign predCtr   = ctrTab[predIdx][hist];
  assign updCtr    = ctrTab[updIdx][hist];
  assign predTaken = predCtr[CTR_W-1];
  assign nextCtr   = strobe.inc ? CTR_W'(updCtr + 1'b1) : CTR_W'(updCtr - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++)
        for (int s = 0; s < SEL_N; s++)
          ctrTab[e][s] <= CTR_INIT;
    end else if (strobe.wrEn) begin
      ctrTab[updIdx][hist] <= nextCtr;
    end
  end

  generate
    if (HIST_LEN == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (!rstN)             hist <= '0;
        else if (strobe.shift) hist <= strobe.bitIn;
      end
    end else begin : g_histN
      always_ff @(posedge clk) begin
        if (!rstN)             hist <= '0;
        else if (strobe.shift) hist <= {hist[HIST_LEN-2:0], strobe.bitIn};
      end
    end
  endgenerate

  // capture of the last written position, used by the checks below
  logic             chkWr;
  logic             chkTaken;
  logic [IDX_W-1:0] chkIdx;
  logic [HIST_LEN-1:0] chkSel;
  logic [CTR_W-1:0] chkOld;
  logic [CTR_W-1:0] chkNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkWr    <= 1'b0;
      chkTaken <= 1'b0;
      chkIdx   <= '0;
      chkSel   <= '0;
      chkOld   <= '0;
    end else begin
      chkWr    <= strobe.shift;
      chkTaken <= strobe.bitIn;
      chkIdx   <= updIdx;
      chkSel   <= hist;
      chkOld   <= updCtr;
    end
  end

  assign chkNow = ctrTab[chkIdx][chkSel];

  // R3: stored value after an update is the saturated step of the old one
  p_sat_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    chkWr |-> (chkTaken ? (chkNow == ((chkOld == CTR_MAX) ? CTR_MAX : CTR_W'(chkOld + 1'b1)))
                        : (chkNow == ((chkOld == '0) ? '0 : CTR_W'(chkOld - 1'b1)))));

  // R5: newest outcome lands in bit 0
  p_hist_newest_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (hist[0] == $past(strobe.bitIn)));

  // R7: history holds without an update
  p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(hist));

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import corr_bp_pkg::*;
#(
  parameter int BUDGET_BITS = 10000,
  parameter int HIST_LEN    = 2,
  parameter int CTR_W       = 2,
  parameter int PC_W        = 32,
  parameter int IDX_LSB     = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  localparam int BITS_PER_ENTRY = (1 << HIST_LEN) * CTR_W;
  localparam int ENTRIES        = calcEntries(BUDGET_BITS, BITS_PER_ENTRY);
  localparam int IDX_W          = $clog2(ENTRIES);

  logic [IDX_W-1:0] predIdx;
  logic [IDX_W-1:0] updIdx;
  logic [CTR_W-1:0] updCtr;
  bpStrobe_t        strobe;
  logic             unusedPcBits;

  assign predIdx      = predPc[IDX_LSB +: IDX_W];
  assign updIdx       = updPc[IDX_LSB +: IDX_W];
  assign unusedPcBits = ^{predPc, updPc};

  corr_bp_ctrl #(
    .CTR_W (CTR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updTaken (updTaken),
    .updCtr   (updCtr),
    .strobe   (strobe)
  );

  corr_bp_datapath #(
    .ENTRIES  (ENTRIES),
    .HIST_LEN (HIST_LEN),
    .CTR_W    (CTR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .predIdx   (predIdx),
    .updIdx    (updIdx),
    .strobe    (strobe),
    .updCtr    (updCtr),
    .predTaken (predTaken)
  );

endmodule

// File: tb/test_corr_branch_predictor.sv
module test_corr_branch_predictor;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] predPc;
  logic        predTaken;
  logic        updValid;
  logic [31:0] updPc;
  logic        updTaken;

  int checks = 0;
  int errors = 0;
  int mdl [1024][4];
  int mdlHist;
  bit done = 0;

  always #10 clk = ~clk;

  corr_branch_predictor i_corr_branch_predictor (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic int idxOf(input logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  function automatic bit expPred(input logic [31:0] pc);
    return mdl[idxOf(pc)][mdlHist] >= 2;
  endfunction

  task automatic mdlUpdate(input logic [31:0] pc, input bit t);
    int c;
    c = mdl[idxOf(pc)][mdlHist];
    if (t) c = (c == 3) ? 3 : c + 1;
    else   c = (c == 0) ? 0 : c - 1;
    mdl[idxOf(pc)][mdlHist] = c;
    mdlHist = ((mdlHist << 1) | int'(t)) & 3;
  endtask

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: predTaken=%0b expected %0b", req, act, exp);
    end
  endtask

  // drive a predict address at the negedge, sample 2 ns later
  task automatic predict(input logic [31:0] pc, input string req);
    @(negedge clk);
    predPc = pc;
    #2;
    check(predTaken, expPred(pc), req);
  endtask

  task automatic update(input logic [31:0] pc, input bit t);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = t;
    @(posedge clk);
    mdlUpdate(pc, t);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rstN = 1'b0; predPc = '0; updValid = 1'b0; updPc = '0; updTaken = 1'b0;
    for (int e = 0; e < 1024; e++) for (int s = 0; s < 4; s++) mdl[e][s] = 1;
    mdlHist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: every entry predicts not-taken after reset
    for (int e = 0; e < 1024; e++) predict(32'(e) << 2, "R1");

    // R3: saturation at the bottom, then climb to the top
    update(32'h100, 1'b0);           // A[00] 01->00
    predict(32'h100, "R3");
    update(32'h100, 1'b0);           // stays 00
    predict(32'h100, "R3");
    for (int k = 0; k < 6; k++) begin
      update(32'h100, 1'b1);
      predict(32'h100, "R2");
    end                              // hist 11, A[11] saturated at 11
    check(predTaken, 1'b1, "R3");

    // R4: aliasing through low bits and above bit 11, neighbour separate
    predict(32'h103, "R4");
    predict(32'h1100, "R4");
    predict(32'hFFFF_F100, "R4");
    check(predTaken, 1'b1, "R4");
    predict(32'h104, "R4");
    check(predTaken, 1'b0, "R4");

    // R7: valid low leaves state alone (B[11] is 01, one step from taken)
    @(negedge clk);
    updValid = 1'b0; updPc = 32'h104; updTaken = 1'b1;
    repeat (4) @(posedge clk);
    predict(32'h104, "R7");
    check(predTaken, 1'b0, "R7");
    predict(32'h100, "R7");
    check(predTaken, 1'b1, "R7");

    // R5/R6: history NT then T selects counter 01
    update(32'h200, 1'b0);
    update(32'h200, 1'b1);           // hist 01
    update(32'h300, 1'b1);           // C[01] 1->2, hist 11
    predict(32'h300, "R5");          // C[11] = 1
    check(predTaken, 1'b0, "R5");
    update(32'h200, 1'b0);
    update(32'h200, 1'b1);           // hist 01 again
    predict(32'h300, "R6");          // C[01] = 2
    check(predTaken, 1'b1, "R6");
    update(32'h200, 1'b1);           // hist 11
    update(32'h200, 1'b0);           // hist 10
    predict(32'h300, "R5");          // C[10] untouched = 1
    check(predTaken, 1'b0, "R5");

    // R8: same-cycle update does not leak into the current prediction
    update(32'h400, 1'b1);           // hist now x1
    @(negedge clk);
    predPc = 32'h400; updPc = 32'h400; updTaken = 1'b1; updValid = 1'b1;
    #2;
    check(predTaken, expPred(32'h400), "R8");
    @(posedge clk);
    mdlUpdate(32'h400, 1'b1);
    @(negedge clk);
    updValid = 1'b0;
    #2;
    check(predTaken, expPred(32'h400), "R8");

    // R2/R3/R6: long mixed run over a small set of entries
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] pc;
      bit t;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pc = {lfsr[31:24], 16'h0, 2'b00, lfsr[3:0], lfsr[9:8]};
      t  = lfsr[3] ? lfsr[12] | lfsr[13] : lfsr[12] & lfsr[13];
      update(pc, t);
      predict(pc, "R6");
      predict({lfsr[23:16], 12'h0, 2'b00, lfsr[7:4], 2'b00} ^ 32'h4, "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule